// File: doc/BRIEF.md
# Dual-Mode 64-bit General-Purpose Timer

A register-mapped timer with two 32-bit counting halves, low and high, each paired with its own period register. A global control word picks how the halves cooperate: one 64-bit counter, two free-standing 32-bit counters, a 64-bit watchdog arrangement (here counting exactly like the 64-bit mode), or a cascade in which the high half acts as a prescaler for the low half. Both halves step on a shared timer tick taken from the core clock through a 4-bit divisor.

Software programs a period of N-1 to get an event every N ticks, clears the count, then sets an enable field to one-shot or continuous. On a match the counting half wraps to zero and a one-cycle event pulse is produced; the low-half pulse also drives an interrupt when its enable bit is set. The register bus is a plain single-cycle port (address, write strobe, write data, combinational read data) with no back-pressure: every write lands at the next clock edge and a read returns current state in the same cycle. Clock-source, pulse-width, prescale and watchdog-control bits are kept and read back but drive nothing.

Top module: `gptimer64`

## Requirements
- R1: After reset every register reads 0 and evt_lo, irq_lo and irq_hi are 0; the block starts disabled in 64-bit mode.
- R2: Byte offsets are 0x04 clock-speed, 0x10/0x14 count low/high, 0x18/0x1C period low/high, 0x20 timer control, 0x24 global control, 0x28 watchdog control. Offsets 0x00, 0x08, 0x0C read 0 and ignore writes. Timer control keeps bits 23:20 and 9:4, bit 0 reads the low event pulse and is not writable; global control keeps bits 15:8 and 3:0; clock-speed keeps only bits 19:16; watchdog control keeps all 32 bits.
- R3: Clock-speed bits 19:16 hold divisor D; a tick occurs every D core clocks (D=0 acts as 1). Writing the clock-speed register restarts the divider, so the first tick falls D clocks after that write.
- R4: Timer-control bits 7:6 (low) and 23:22 (high) select 00 off, 01 one-shot, 10 continuous. In split mode (global bits 3:2 = 01) a running half increments per tick; when its count equals its period it becomes 0 and raises a one-cycle event, so a period of N-1 gives one event per N ticks.
- R5: In one-shot mode the matching half clears its enable field to 00 at the event and then stays at 0.
- R6: With the enable field 00 the count holds its value.
- R7: Global bit 0 (low) and bit 1 (high) hold the corresponding half at 0 while 0; in the 64-bit modes both bits must be 1 for either half to run.
- R8: In 64-bit mode (global bits 3:2 = 00 or 10) the low half runs on the low enable field, carries into the high half when it passes all-ones, and the event fires when both halves equal their periods, clearing both.
- R9: In cascade mode (global bits 3:2 = 11) the high half counts ticks under the low enable field and wraps at its period; the low half steps once per high wrap and signals the event at its own period.
- R10: irq_lo pulses with the low event only when timer-control bit 9 is 1; irq_hi pulses with the high-half event in split mode only.
- R11: A bus write to a count register wins over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_lo | output | 1 | One-cycle low-half (or 64-bit) event |
| irq_lo | output | 1 | Low event gated by the interrupt enable |
| irq_hi | output | 1 | High-half event in split mode |

## Verification
The bench builds the block with its defaults, a 32-bit data word and a 4-bit divisor field. With 32-bit halves the carry from low to high is reached by preloading the low count just below all-ones instead of waiting for it, and the 4-bit divisor lets the bench set a divide-by-4 tick and read the resulting count at an exact edge, plus the full 15 in the read-back check. Small periods (1, 2, 4) keep each wrap, one-shot stop and cascade step within a dozen cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int AW = 6;

  localparam logic [AW-1:0] OFS_CLK    = 6'h04;
  localparam logic [AW-1:0] OFS_CNT_LO = 6'h10;
  localparam logic [AW-1:0] OFS_CNT_HI = 6'h14;
  localparam logic [AW-1:0] OFS_PRD_LO = 6'h18;
  localparam logic [AW-1:0] OFS_PRD_HI = 6'h1C;
  localparam logic [AW-1:0] OFS_CTL    = 6'h20;
  localparam logic [AW-1:0] OFS_GCTL   = 6'h24;
  localparam logic [AW-1:0] OFS_WDOG   = 6'h28;

  localparam int DIV_LSB    = 16;
  localparam int EN_LO_LSB  = 6;
  localparam int EN_HI_LSB  = 22;
  localparam int IEN_BIT    = 9;
  localparam int MODE_LSB   = 2;

  typedef enum logic [1:0] {
    MODE_WIDE    = 2'b00,
    MODE_SPLIT   = 2'b01,
    MODE_WDOG    = 2'b10,
    MODE_CASCADE = 2'b11
  } tmode_e;

  typedef enum logic [1:0] {
    EN_OFF  = 2'b00,
    EN_ONCE = 2'b01,
    EN_RUN  = 2'b10,
    EN_RSV  = 2'b11
  } enmode_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div == '0) ? DIV_W'(1) : div;
  assign tick    = (phase >= div_eff - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (tick)    phase <= '0;
    else              phase <= phase + DIV_W'(1);
  end
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  input  logic         clr,
  input  logic [W-1:0] prd,
  output logic [W-1:0] cnt,
  output logic         hit,
  output logic         full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (hold) cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (inc)  cnt <= clr ? '0 : cnt + W'(1);
  end

  assign hit  = (cnt == prd);
  assign full = &cnt;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             once_lo,
  input  logic             once_hi,
  output logic [DW-1:0]    emu_q,
  output logic [DW-1:0]    ctl_q,
  output logic [DW-1:0]    gctl_q,
  output logic [DW-1:0]    wdog_q,
  output logic [DW-1:0]    prd_lo,
  output logic [DW-1:0]    prd_hi,
  output logic [DIV_W-1:0] div,
  output logic             div_wr
);
  localparam logic [DW-1:0] CTL_KEEP  = DW'(32'h00F0_03F0);
  localparam logic [DW-1:0] GCTL_KEEP = DW'(32'h0000_FF0F);
  localparam logic [DW-1:0] EMU_KEEP  = DW'({DIV_W{1'b1}}) << DIV_LSB;

  assign div    = emu_q[DIV_LSB +: DIV_W];
  assign div_wr = we && (addr == OFS_CLK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emu_q  <= '0;
      ctl_q  <= '0;
      gctl_q <= '0;
      wdog_q <= '0;
      prd_lo <= '0;
      prd_hi <= '0;
    end else begin
      if (div_wr)                          emu_q  <= wdata & EMU_KEEP;
      if (we && addr == OFS_GCTL)          gctl_q <= wdata & GCTL_KEEP;
      if (we && addr == OFS_WDOG)          wdog_q <= wdata;
      if (we && addr == OFS_PRD_LO)        prd_lo <= wdata;
      if (we && addr == OFS_PRD_HI)        prd_hi <= wdata;
      if (we && addr == OFS_CTL) begin
        ctl_q <= wdata & CTL_KEEP;
      end else begin
        if (once_lo) ctl_q[EN_LO_LSB +: 2] <= EN_OFF;
        if (once_hi) ctl_q[EN_HI_LSB +: 2] <= EN_OFF;
      end
    end
  end
endmodule

// File: rtl/gptimer64.sv
module gptimer64
  import tmr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DIV_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          evt_lo,
  output logic          irq_lo,
  output logic          irq_hi
);
  logic [DW-1:0]    emu_q, ctl_q, gctl_q, wdog_q, prd_lo, prd_hi;
  logic [DW-1:0]    cnt_lo, cnt_hi;
  logic [DIV_W-1:0] div;
  logic             div_wr, tick;
  logic             hit_lo, hit_hi, full_lo, full_hi;
  logic             hold_lo, hold_hi, inc_lo, inc_hi, clr_lo, clr_hi;
  logic             ev_lo, ev_hi, once_lo, once_hi;
  logic             run_lo, run_hi;
  logic [1:0]       rs;
  tmode_e           mode;
  enmode_e          en_lo, en_hi;

  tmr_regs #(.DW(DW), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .once_lo(once_lo), .once_hi(once_hi),
    .emu_q(emu_q), .ctl_q(ctl_q), .gctl_q(gctl_q), .wdog_q(wdog_q),
    .prd_lo(prd_lo), .prd_hi(prd_hi), .div(div), .div_wr(div_wr)
  );

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div(div), .restart(div_wr), .tick(tick)
  );

  tmr_half #(.W(DW)) u_lo (
    .clk(clk), .rst_n(rst_n), .hold(hold_lo),
    .ld(bus_we && bus_addr == OFS_CNT_LO), .ld_val(bus_wdata),
    .inc(inc_lo), .clr(clr_lo), .prd(prd_lo),
    .cnt(cnt_lo), .hit(hit_lo), .full(full_lo)
  );

  tmr_half #(.W(DW)) u_hi (
    .clk(clk), .rst_n(rst_n), .hold(hold_hi),
    .ld(bus_we && bus_addr == OFS_CNT_HI), .ld_val(bus_wdata),
    .inc(inc_hi), .clr(clr_hi), .prd(prd_hi),
    .cnt(cnt_hi), .hit(hit_hi), .full(full_hi)
  );

  assign mode   = tmode_e'(gctl_q[MODE_LSB +: 2]);
  assign rs     = gctl_q[1:0];
  assign en_lo  = enmode_e'(ctl_q[EN_LO_LSB +: 2]);
  assign en_hi  = enmode_e'(ctl_q[EN_HI_LSB +: 2]);
  assign run_lo = (en_lo != EN_OFF);
  assign run_hi = (en_hi != EN_OFF);

  always_comb begin
    hold_lo = !rs[0];
    hold_hi = !rs[1];
    inc_lo  = 1'b0;
    inc_hi  = 1'b0;
    clr_lo  = 1'b0;
    clr_hi  = 1'b0;
    ev_lo   = 1'b0;
    ev_hi   = 1'b0;
    unique case (mode)
      MODE_SPLIT: begin
        inc_lo = tick && run_lo;
        clr_lo = hit_lo;
        inc_hi = tick && run_hi;
        clr_hi = hit_hi;
        ev_lo  = inc_lo && hit_lo && !hold_lo;
        ev_hi  = inc_hi && hit_hi && !hold_hi;
      end
      MODE_CASCADE: begin
        inc_hi = tick && run_lo;
        clr_hi = hit_hi;
        inc_lo = inc_hi && hit_hi && !hold_hi;
        clr_lo = hit_lo;
        ev_lo  = inc_lo && hit_lo && !hold_lo;
      end
      default: begin
        hold_lo = (rs != 2'b11);
        hold_hi = hold_lo;
        inc_lo  = tick && run_lo;
        clr_lo  = hit_lo && hit_hi;
        inc_hi  = inc_lo && (full_lo || clr_lo);
        clr_hi  = clr_lo;
        ev_lo   = inc_lo && clr_lo && !hold_lo;
      end
    endcase
  end

  assign once_lo = ev_lo && (en_lo == EN_ONCE);
  assign once_hi = ev_hi && (en_hi == EN_ONCE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_lo <= 1'b0;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      evt_lo <= ev_lo;
      irq_lo <= ev_lo && ctl_q[IEN_BIT];
      irq_hi <= ev_hi;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CLK:    bus_rdata = emu_q;
      OFS_CNT_LO: bus_rdata = cnt_lo;
      OFS_CNT_HI: bus_rdata = cnt_hi;
      OFS_PRD_LO: bus_rdata = prd_lo;
      OFS_PRD_HI: bus_rdata = prd_hi;
      OFS_CTL:    bus_rdata = ctl_q | DW'(evt_lo);
      OFS_GCTL:   bus_rdata = gctl_q;
      OFS_WDOG:   bus_rdata = wdog_q;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [1:0]    rs,
  input logic [1:0]    en_lo,
  input logic          ien,
  input logic [DW-1:0] cnt_lo,
  input logic          evt_lo,
  input logic          irq_lo
);
  AST_EVT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_lo && !$past(we && addr == OFS_CNT_LO)) |-> (cnt_lo == '0)); // R4

  AST_ONCE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_lo && $past(en_lo == 2'b01) && !$past(we && addr == OFS_CTL)) |-> (en_lo == 2'b00)); // R5

  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lo == 2'b00 && rs == 2'b11 && !(we && addr == OFS_CNT_LO)) |=> $stable(cnt_lo)); // R6

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !rs[0] |=> (cnt_lo == '0)); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> ($past(ien) && evt_lo)); // R10
endmodule

bind gptimer64 tmr_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
  .rs(gctl_q[1:0]), .en_lo(ctl_q[7:6]), .ien(ctl_q[9]),
  .cnt_lo(cnt_lo), .evt_lo(evt_lo), .irq_lo(irq_lo)
);

// File: tb/gptimer64_tb.sv
module gptimer64_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_lo, irq_lo, irq_hi;

  int n_vec = 0, n_bad = 0;
  int n_evt = 0, n_irq = 0, n_hi = 0;
  bit done = 1'b0;

  typedef struct {
    logic [5:0]  a;
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t sb[$];

  gptimer64 u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_lo(evt_lo), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares scoreboard entries a little after each falling edge
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      n_vec++;
      if (bus_rdata !== it.d) begin
        n_bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, bus_rdata, it.d);
      end
    end
  end

  // pulse counters
  always @(negedge clk) begin
    #2;
    if (evt_lo) n_evt++;
    if (irq_lo) n_irq++;
    if (irq_hi) n_hi++;
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] d, input string tag);
    exp_t it;
    @(negedge clk);
    bus_addr = a;
    it.a = a; it.d = d; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chkv(input int act, input int exp, input string tag);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chkv(int'(evt_lo), 0, "R1 evt_lo");
    chkv(int'(irq_lo), 0, "R1 irq_lo");
    chkv(int'(irq_hi), 0, "R1 irq_hi");
    rd(6'h04, 32'h0, "R1 clk reg");
    rd(6'h10, 32'h0, "R1 cnt lo");
    rd(6'h18, 32'h0, "R1 prd lo");
    rd(6'h20, 32'h0, "R1 ctl");
    rd(6'h24, 32'h0, "R1 gctl");

    // R2 map and stored-only fields
    wr(6'h20, 32'h0030_0331); rd(6'h20, 32'h0030_0330, "R2 ctl keep");
    wr(6'h28, 32'hDEAD_BEEF); rd(6'h28, 32'hDEAD_BEEF, "R2 wdog");
    wr(6'h08, 32'h0000_1234); rd(6'h08, 32'h0, "R2 reserved");
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, 32'h000F_0000, "R2 clk keep");
    wr(6'h24, 32'h0000_FFFF); rd(6'h24, 32'h0000_FF0F, "R2 gctl keep");
    wr(6'h1C, 32'h0000_0077); rd(6'h1C, 32'h77, "R2 prd hi");
    wr(6'h04, 32'h0); wr(6'h24, 32'h0); wr(6'h20, 32'h0);

    // R4 split continuous, period 4 -> every 5 ticks
    wr(6'h24, 32'h7); wr(6'h18, 32'd4); wr(6'h10, 32'd0); wr(6'h20, 32'h280);
    n_irq = 0; n_evt = 0;
    repeat (11) @(negedge clk);
    rd(6'h10, 32'd2, "R4 count after 12 ticks");
    #3;
    chkv(n_irq, 2, "R4 events in 12 ticks");
    // R10 interrupt gate off
    wr(6'h20, 32'h080);
    n_irq = 0; n_evt = 0; n_hi = 0;
    repeat (10) @(negedge clk);
    #3;
    chkv(n_irq, 0, "R10 irq gated off");
    chkv(n_evt, 2, "R10 evt still pulses");
    chkv(n_hi, 0, "R10 irq_hi quiet");

    // R11 load wins over counting
    wr(6'h18, 32'd100); wr(6'h10, 32'd50);
    rd(6'h10, 32'd51, "R11 load then count");
    // R6 frozen when off
    wr(6'h20, 32'h0); wr(6'h10, 32'd3);
    rd(6'h10, 32'd3, "R6 loaded");
    repeat (6) @(negedge clk);
    rd(6'h10, 32'd3, "R6 held");

    // R5 one-shot
    wr(6'h18, 32'd2); wr(6'h10, 32'd0);
    n_irq = 0;
    wr(6'h20, 32'h240);
    repeat (8) @(negedge clk);
    rd(6'h20, 32'h200, "R5 enable cleared");
    rd(6'h10, 32'd0, "R5 stays zero");
    #3;
    chkv(n_irq, 1, "R5 single event");

    // R7 run/reset bit
    wr(6'h18, 32'd100); wr(6'h20, 32'h080);
    repeat (3) @(negedge clk);
    wr(6'h24, 32'h6);
    rd(6'h10, 32'd0, "R7 held low");
    repeat (4) @(negedge clk);
    rd(6'h10, 32'd0, "R7 still held");
    wr(6'h24, 32'h7); wr(6'h20, 32'h0);

    // R10 high half in split mode, period 2
    wr(6'h14, 32'd0); wr(6'h1C, 32'd2); wr(6'h20, 32'h0080_0000);
    n_hi = 0; n_evt = 0;
    repeat (8) @(negedge clk);
    #3;
    chkv(n_hi, 2, "R10 irq_hi count");
    chkv(n_evt, 0, "R4 low off no events");
    rd(6'h14, 32'd0, "R4 high wraps");
    wr(6'h20, 32'h0);

    // R8 64-bit carry and joint match
    wr(6'h24, 32'h3); wr(6'h18, 32'd1); wr(6'h1C, 32'd1);
    wr(6'h10, 32'hFFFF_FFFE); wr(6'h14, 32'd0); wr(6'h20, 32'h280);
    n_evt = 0;
    rd(6'h10, 32'hFFFF_FFFF, "R8 low near top");
    rd(6'h14, 32'd1, "R8 carry into high");
    rd(6'h10, 32'd1, "R8 low restart");
    rd(6'h14, 32'd0, "R8 joint match clears");
    @(negedge clk); #3;
    chkv(n_evt, 1, "R8 one event");
    wr(6'h20, 32'h0);

    // R9 cascade
    wr(6'h24, 32'hF); wr(6'h10, 32'd0); wr(6'h14, 32'd0);
    wr(6'h1C, 32'd2); wr(6'h18, 32'd1); wr(6'h20, 32'h280);
    n_evt = 0;
    rd(6'h10, 32'd0, "R9 low waits");
    repeat (2) @(negedge clk);
    rd(6'h10, 32'd1, "R9 low steps per high wrap");
    repeat (8) @(negedge clk);
    #3;
    chkv(n_evt, 2, "R9 cascade events");
    wr(6'h20, 32'h0);

    // R3 divide by 4
    wr(6'h24, 32'h7); wr(6'h18, 32'd100); wr(6'h10, 32'd0);
    wr(6'h04, 32'h0004_0000); wr(6'h20, 32'h080);
    repeat (10) @(negedge clk);
    rd(6'h10, 32'd3, "R3 divided ticks");
    wr(6'h20, 32'h0); wr(6'h04, 32'h0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule